// File: doc/BRIEF.md
# Bit-Pipelined Signed Array Multiplier

This block multiplies two 8-bit two's complement operands and returns their 16-bit two's complement product. A new operand pair can be presented on every clock, and each product appears a fixed 12 cycles after its operands were taken. A qualifying valid bit travels alongside the data, so a stream of products comes out with the same cycle spacing as the operands that went in.

Internally the operands pass through a carry-save array, one row per bit of the second operand. There is one register stage per row. The bits of the second operand are carried down a staggered register chain, so that each row picks up its own bit in the cycle in which the running sum and carry vectors reach it. Signed partial products use the modified Baugh-Wooley form. Terms that involve exactly one sign bit are inverted, and a fixed correction word is loaded into the carry vector of the first row. After the last row, a segmented merge adder resolves the sum and carry vectors into one word, four bits per stage. Segments that are resolved early are held in deskew registers until every segment is done, so all sixteen product bits leave in the same cycle.

Top module: `bw_pipe_mul`

## Requirements
- R1: When `out_valid` is high, `product` equals the 16-bit two's complement value of signed `a_in` times signed `b_in` as sampled together 12 cycles earlier.
- R2: `out_valid` is high in exactly those cycles that come 12 rising edges after an edge at which `in_valid` was sampled high.
- R3: Operand pairs presented on consecutive cycles, with no idle cycle between them, each yield their own correct product on consecutive output cycles.
- R4: While `rst_n` is low, and in the cycles after its release until the first valid operand pair has travelled through, `out_valid` is low.
- R5: Operands `a_in` = 8'hFF (−1) and `b_in` = 8'h55 (85) give `product` = 16'hFFAB (−85).
- R6: The extreme operand −128 is handled exactly: −128 × −128 gives 16'h4000 (+16384), and −128 × 127 gives 16'hC080 (−16256).
- R7: An edge at which `in_valid` is low produces `out_valid` low 12 cycles later, whatever values `a_in` and `b_in` carry at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the valid pipeline |
| in_valid | input | 1 | Qualifies `a_in` and `b_in` at this edge |
| a_in | input | 8 | Multiplicand, two's complement |
| b_in | input | 8 | Multiplier, two's complement; its bits feed the array rows one stage apart |
| out_valid | output | 1 | High when `product` holds a result |
| product | output | 16 | Two's complement product |

## Verification
Faults in this pipeline show up at the port in distinct ways. A corrupted sum or carry bit inside the array, a mis-inverted Baugh-Wooley term or a wrong correction constant gives a wrong product for the affected operand pair, and only for that pair. A skew chain that is off by one stage mixes a bit of a neighbouring operand into the result, so the fault shows only when adjacent operand pairs differ. That is why every pair of operand values is driven back to back. A broken deskew register or merge carry corrupts one four-bit field of the product. A slip in the valid chain moves `out_valid` off the 12th cycle. Each of these faults appears exactly 12 cycles after the pair concerned enters the block.

// File: rtl/bw_csa_row.sv
// One registered row of the carry-save array. The row forms its Baugh-Wooley
// partial product from the operand A and bit ROW of operand B, compresses it into
// the running sum/carry pair with one full adder per bit, and hands everything
// on, including the operands, one cycle later.
module bw_csa_row #(
   parameter int N   = 8,
   parameter int ROW = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             v_i,
   input  logic [N-1:0]     a_i,
   input  logic [N-1:0]     b_i,
   input  logic [2*N-1:0]   s_i,
   input  logic [2*N-1:0]   c_i,
   output logic             v_o,
   output logic [N-1:0]     a_o,
   output logic [N-1:0]     b_o,
   output logic [2*N-1:0]   s_o,
   output logic [2*N-1:0]   c_o
);
   localparam int W = 2 * N;

   logic [W-1:0] pp;
   logic [W-1:0] s_n;
   logic [W-1:0] maj;

   // Partial product: a term with exactly one sign bit in it is inverted
   always_comb begin
      pp = '0;
      for (int j = 0; j < N; j++) begin
         if ((j == N - 1) != (ROW == N - 1))
            pp[ROW + j] = ~(a_i[j] & b_i[ROW]);
         else
            pp[ROW + j] = a_i[j] & b_i[ROW];
      end
   end

   // 3:2 compression, one full adder per bit position
   assign s_n = s_i ^ c_i ^ pp;
   assign maj = (s_i & c_i) | (s_i & pp) | (c_i & pp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_o <= 1'b0;
      else        v_o <= v_i;
   end

   always_ff @(posedge clk) begin
      a_o <= a_i;
      b_o <= b_i;
      s_o <= s_n;
      c_o <= {maj[W-2:0], 1'b0};
   end

   // R2
   row_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |=> v_o);
   // R7
   row_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !v_i |=> !v_o);
endmodule

// File: rtl/bw_merge_seg.sv
// One stage of the segmented vector-merge adder. It resolves segment K of the
// sum/carry pair with the carry from the segment below and keeps earlier
// segments in deskew registers.
module bw_merge_seg #(
   parameter int W     = 16,
   parameter int SEG_W = 4,
   parameter int K     = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           v_i,
   input  logic [W-1:0]   s_i,
   input  logic [W-1:0]   c_i,
   input  logic [W-1:0]   r_i,
   input  logic           cy_i,
   output logic           v_o,
   output logic [W-1:0]   s_o,
   output logic [W-1:0]   c_o,
   output logic [W-1:0]   r_o,
   output logic           cy_o
);
   localparam int LO = K * SEG_W;

   logic [SEG_W:0] seg_sum;
   logic [W-1:0]   r_n;

   assign seg_sum = {1'b0, s_i[LO +: SEG_W]} + {1'b0, c_i[LO +: SEG_W]}
                  + {{SEG_W{1'b0}}, cy_i};

   always_comb begin
      r_n = r_i;
      r_n[LO +: SEG_W] = seg_sum[SEG_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_o <= 1'b0;
      else        v_o <= v_i;
   end

   always_ff @(posedge clk) begin
      s_o  <= s_i;
      c_o  <= c_i;
      r_o  <= r_n;
      cy_o <= seg_sum[SEG_W];
   end

   // R2
   merge_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |=> v_o);
   // R7
   merge_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !v_i |=> !v_o);
endmodule

// File: rtl/bw_pipe_mul.sv
// Bit-pipelined signed array multiplier: N carry-save rows, then a merge adder
// of SEG_W-bit segments, with one register stage per row and per segment.
module bw_pipe_mul #(
   parameter int N       = 8,
   parameter int SEG_W   = 4,
   parameter int LATENCY = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [N-1:0]     a_in,
   input  logic [N-1:0]     b_in,
   output logic             out_valid,
   output logic [2*N-1:0]   product
);
   localparam int W    = 2 * N;
   localparam int SEGS = W / SEG_W;
   // Baugh-Wooley correction word: 2^N + 2^(2N-1)
   localparam logic [W-1:0] BW_FIX = (W'(1) << N) | (W'(1) << (W - 1));

   if (N < 2) begin : g_bad_n
      $error("bw_pipe_mul: N must be at least 2");
   end
   if (SEG_W < 1 || (W % SEG_W) != 0) begin : g_bad_seg
      $error("bw_pipe_mul: SEG_W must divide 2*N");
   end
   if (LATENCY != N + SEGS) begin : g_bad_lat
      $error("bw_pipe_mul: LATENCY must equal N + 2*N/SEG_W");
   end

   // Array pipeline, index k is the input of row k
   logic           rv [0:N];
   logic [N-1:0]   ra [0:N];
   logic [N-1:0]   rb [0:N];
   logic [W-1:0]   rs [0:N];
   logic [W-1:0]   rc [0:N];

   assign rv[0] = in_valid;
   assign ra[0] = a_in;
   assign rb[0] = b_in;
   assign rs[0] = '0;
   assign rc[0] = BW_FIX;

   for (genvar k = 0; k < N; k++) begin : g_row
      bw_csa_row #(.N(N), .ROW(k)) i_row (
         .clk(clk), .rst_n(rst_n),
         .v_i(rv[k]),   .a_i(ra[k]),   .b_i(rb[k]),
         .s_i(rs[k]),   .c_i(rc[k]),
         .v_o(rv[k+1]), .a_o(ra[k+1]), .b_o(rb[k+1]),
         .s_o(rs[k+1]), .c_o(rc[k+1])
      );
   end

   // Merge pipeline, index k is the input of segment stage k
   logic           mv  [0:SEGS];
   logic [W-1:0]   ms  [0:SEGS];
   logic [W-1:0]   mc  [0:SEGS];
   logic [W-1:0]   mr  [0:SEGS];
   logic           mcy [0:SEGS];

   assign mv[0]  = rv[N];
   assign ms[0]  = rs[N];
   assign mc[0]  = rc[N];
   assign mr[0]  = '0;
   assign mcy[0] = 1'b0;

   for (genvar k = 0; k < SEGS; k++) begin : g_seg
      bw_merge_seg #(.W(W), .SEG_W(SEG_W), .K(k)) i_seg (
         .clk(clk), .rst_n(rst_n),
         .v_i(mv[k]),   .s_i(ms[k]),   .c_i(mc[k]),
         .r_i(mr[k]),   .cy_i(mcy[k]),
         .v_o(mv[k+1]), .s_o(ms[k+1]), .c_o(mc[k+1]),
         .r_o(mr[k+1]), .cy_o(mcy[k+1])
      );
   end

   assign out_valid = mv[SEGS];
   assign product   = mr[SEGS];

   // Arithmetic reference for the array output alone
   logic [W-1:0] arr_ref;
   assign arr_ref = W'($signed({{N{ra[N][N-1]}}, ra[N]}) * $signed({{N{rb[N][N-1]}}, rb[N]}));

   // R1
   array_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rv[N] |-> (W'(rs[N] + rc[N]) == arr_ref));
   // R4
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !out_valid);
endmodule

// File: tb/test_bw_pipe_mul.sv
module test_bw_pipe_mul;
   localparam int LAT = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  a_in = '0;
   logic [7:0]  b_in = '0;
   logic        out_valid;
   logic [15:0] product;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // Expected-value history, entry LAT-1 is due at the current sample point
   logic        hv [0:LAT-1];
   logic [15:0] hp [0:LAT-1];
   string       ht [0:LAT-1];

   always #10 clk = ~clk;

   bw_pipe_mul i_bw_pipe_mul (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .a_in(a_in), .b_in(b_in),
      .out_valid(out_valid), .product(product)
   );

   function automatic logic [15:0] mul_ref(input logic [7:0] a, input logic [7:0] b);
      int pa = int'($signed(a));
      int pb = int'($signed(b));
      int pr = pa * pb;
      return pr[15:0];
   endfunction

   task automatic check_out();
      tests++;
      if (out_valid !== hv[LAT-1]) begin
         fails++;
         $display("FAIL %s/R2: out_valid=%0b expected %0b", ht[LAT-1], out_valid, hv[LAT-1]);
      end else if (hv[LAT-1] && product !== hp[LAT-1]) begin
         fails++;
         $display("FAIL %s/R1: product=%h expected %h", ht[LAT-1], product, hp[LAT-1]);
      end
   endtask

   // At a falling edge: check what is due, then present the next input
   task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b, input string tag);
      @(negedge clk);
      check_out();
      for (int i = LAT - 1; i > 0; i--) begin
         hv[i] = hv[i-1];
         hp[i] = hp[i-1];
         ht[i] = ht[i-1];
      end
      hv[0] = v;
      hp[0] = mul_ref(a, b);
      ht[0] = v ? tag : "R7";
      in_valid = v;
      a_in = a;
      b_in = b;
   endtask

   initial begin
      for (int i = 0; i < LAT; i++) begin
         hv[i] = 1'b0;
         hp[i] = '0;
         ht[i] = "R4";
      end
      // R4: quiet while held in reset, with junk on the operand pins
      repeat (3) begin
         @(negedge clk);
         in_valid = 1'b1;
         a_in = 8'h3C;
         b_in = 8'hA5;
         tests++;
         if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R4: out_valid=%0b expected 0 in reset", out_valid);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b1;
      // R5 and R6 directed, separated by idle cycles
      step(1'b1, 8'hFF, 8'h55, "R5");
      step(1'b0, 8'h77, 8'h99, "R7");
      step(1'b1, 8'h80, 8'h80, "R6");
      step(1'b1, 8'h80, 8'h7F, "R6");
      step(1'b1, 8'h7F, 8'h80, "R6");
      step(1'b1, 8'h7F, 8'h7F, "R6");
      // R7: idle cycles with busy operands between valid ones
      for (int i = 0; i < 20; i++)
         step(i[0], 8'(i * 37), 8'(i * 91 + 5), "R7");
      // R3: every operand pair, back to back
      for (int k = 0; k < 65536; k++)
         step(1'b1, k[15:8], k[7:0], "R3");
      // drain
      for (int i = 0; i <= LAT; i++)
         step(1'b0, 8'h00, 8'h00, "R7");
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(posedge clk);
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule